// File: doc/BRIEF.md
# Saturating Partial Vector Sum-Across Unit

This execution unit handles one SIMD instruction. It takes two 128-bit operands, A and B, and treats each as four signed 32-bit words. It splits each operand into two 64-bit halves (doublewords). In each half it adds the two A words to the odd word of B. It clamps the total to the signed 32-bit range and writes it to the odd word of that half of the result. The even result words are always zero.

The unit returns the result one cycle after an accepted request. It also returns a two-bit per-operation flag that shows which halves were clamped, and it keeps a sticky saturation status bit that only a dedicated clear input can reset. When the vector facility is disabled, a request is not executed. The unit raises a vector-unavailable pulse instead and leaves all held state untouched.

Top module: `psum_sat_unit`

## Requirements
- R1: Result word 1 (bits [95:64]) equals the signed sum A.word0 + A.word1 + B.word1, where word 0 is bits [127:96] and word 1 is bits [95:64].
- R2: Result word 3 (bits [31:0]) equals the signed sum A.word2 + A.word3 + B.word3, where word 2 is bits [63:32] and word 3 is bits [31:0].
- R3: Result words 0 and 2 are always 0x00000000, and the even words of B have no effect on the result.
- R4: Each three-term sum is formed without internal overflow and then clamped: a total above 0x7FFFFFFF gives 0x7FFFFFFF, a total below 0x80000000 gives 0x80000000, and a total that fits is passed through exactly, even when a partial sum of two terms would overflow 32 bits.
- R5: `lane_sat_o` bit 0 is 1 exactly when the word-1 sum was clamped, and bit 1 is 1 exactly when the word-3 sum was clamped, for the most recent executed operation.
- R6: `sat_sticky_o` becomes 1 on the cycle after an executed operation that clamped either sum, and stays 1 through later operations that do not clamp.
- R7: A `sat_clr_i` pulse clears `sat_sticky_o` on the next cycle. If an executed operation in the same cycle clamps, the sticky bit ends at 1.
- R8: `out_valid_o` is 1 exactly one cycle after a cycle with `in_valid_i` = 1 and `vec_en_i` = 1, and 0 otherwise.
- R9: A request with `vec_en_i` = 0 is not executed. `unavail_o` is 1 on the next cycle, `out_valid_o` stays 0, and `result_o`, `lane_sat_o` and `sat_sticky_o` keep their values.
- R10: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request strobe |
| vec_en_i | input | 1 | Vector facility enable |
| sat_clr_i | input | 1 | Clears the sticky saturation bit |
| opa_i | input | 128 | Operand A, word 0 in the top 32 bits |
| opb_i | input | 128 | Operand B; only its odd words are used |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 128 | Result vector, held between operations |
| lane_sat_o | output | 2 | Per-half clamp flags of the last executed operation |
| sat_sticky_o | output | 1 | Sticky saturation status |
| unavail_o | output | 1 | Vector-unavailable exception pulse |

## Verification
The bench applies totals that land exactly on each limit, one past each limit, and cases where a two-term partial sum overflows 32 bits but the three-term total fits. A design with a 33-bit adder, or one that saturated step by step, would clamp those cases wrongly. It puts nonzero values in the even words of B, which a lane-indexing mistake would leak into the result. It issues one-sided saturations to catch swapped flag bits. It tests clear and set in the same cycle, and sends a saturating request while the facility is disabled. A design that got that last case wrong would disturb the held result or the sticky bit.

// File: rtl/psum_pkg.sv
package psum_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_EXEC    = 2'd1,
    OP_UNAVAIL = 2'd2
  } op_e;

  function automatic op_e op_decode(input logic vld, input logic en);
    if (!vld)     return OP_IDLE;
    else if (en)  return OP_EXEC;
    else          return OP_UNAVAIL;
  endfunction

endpackage

// File: rtl/psum_lane.sv
module psum_lane #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] a_hi_i,
  input  logic [WORD_W-1:0] a_lo_i,
  input  logic [WORD_W-1:0] acc_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              sat_o
);
  // Three signed terms need two guard bits.
  localparam int SUM_W = WORD_W + 2;
  localparam int EXT_W = SUM_W - WORD_W;

  localparam logic [SUM_W-1:0] MAX_S = {{(EXT_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic [SUM_W-1:0] MIN_S = {{(EXT_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  logic signed [SUM_W-1:0] a_hi_x, a_lo_x, acc_x, total;

  always_comb begin
    a_hi_x = $signed({{EXT_W{a_hi_i[WORD_W-1]}}, a_hi_i});
    a_lo_x = $signed({{EXT_W{a_lo_i[WORD_W-1]}}, a_lo_i});
    acc_x  = $signed({{EXT_W{acc_i[WORD_W-1]}},  acc_i});
    total  = a_hi_x + a_lo_x + acc_x;
  end

  always_comb begin
    if (total > $signed(MAX_S)) begin
      sum_o = MAX_S[WORD_W-1:0];
      sat_o = 1'b1;
    end else if (total < $signed(MIN_S)) begin
      sum_o = MIN_S[WORD_W-1:0];
      sat_o = 1'b1;
    end else begin
      sum_o = total[WORD_W-1:0];
      sat_o = 1'b0;
    end
  end

endmodule

// File: rtl/psum_sticky.sv
module psum_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sticky_o
);
  logic sticky_q, sticky_d;

  always_comb begin
    sticky_d = (clr_i ? 1'b0 : sticky_q) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= 1'b0;
    else         sticky_q <= sticky_d;
  end

  assign sticky_o = sticky_q;

  // R6
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_o && !clr_i) |=> sticky_o);

  // R7
  sticky_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !sticky_o);

  // R7
  sticky_setwin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> sticky_o);

endmodule

// File: rtl/psum_sat_unit.sv
module psum_sat_unit
  import psum_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic                        vec_en_i,
  input  logic                        sat_clr_i,
  input  logic [2*LANES*WORD_W-1:0]   opa_i,
  input  logic [2*LANES*WORD_W-1:0]   opb_i,
  output logic                        out_valid_o,
  output logic [2*LANES*WORD_W-1:0]   result_o,
  output logic [LANES-1:0]            lane_sat_o,
  output logic                        sat_sticky_o,
  output logic                        unavail_o
);
  localparam int DW_W  = 2 * WORD_W;
  localparam int VEC_W = LANES * DW_W;

  op_e                op;
  logic [VEC_W-1:0]   lane_res;
  logic [LANES-1:0]   lane_sat;
  logic               exec_en;

  logic [VEC_W-1:0]   result_q, result_d;
  logic [LANES-1:0]   lane_sat_q, lane_sat_d;
  logic               valid_q, valid_d;
  logic               unavail_q, unavail_d;
  logic               sat_set;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int TOP = VEC_W - 1 - g * DW_W;
    logic [WORD_W-1:0] sum_w;
    logic              unused_b_even;

    assign unused_b_even = ^opb_i[TOP -: WORD_W];

    psum_lane #(.WORD_W(WORD_W)) lane_i (
      .a_hi_i (opa_i[TOP -: WORD_W]),
      .a_lo_i (opa_i[TOP-WORD_W -: WORD_W]),
      .acc_i  (opb_i[TOP-WORD_W -: WORD_W]),
      .sum_o  (sum_w),
      .sat_o  (lane_sat[g])
    );

    assign lane_res[TOP -: DW_W] = {{WORD_W{1'b0}}, sum_w};

    // R3
    even_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (result_o[TOP -: WORD_W] == '0));
  end

  // Next-state logic
  always_comb begin
    op         = op_decode(in_valid_i, vec_en_i);
    exec_en    = (op == OP_EXEC);
    result_d   = result_q;
    lane_sat_d = lane_sat_q;
    if (exec_en) begin
      result_d   = lane_res;
      lane_sat_d = lane_sat;
    end
    valid_d   = exec_en;
    unavail_d = (op == OP_UNAVAIL);
    sat_set   = exec_en & (|lane_sat);
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q   <= '0;
      lane_sat_q <= '0;
    end else if (exec_en) begin
      result_q   <= result_d;
      lane_sat_q <= lane_sat_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      unavail_q <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      unavail_q <= unavail_d;
    end
  end

  psum_sticky sticky_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (sat_set),
    .clr_i    (sat_clr_i),
    .sticky_o (sat_sticky_o)
  );

  assign out_valid_o = valid_q;
  assign result_o    = result_q;
  assign lane_sat_o  = lane_sat_q;
  assign unavail_o   = unavail_q;

  // R8
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && vec_en_i) |=> out_valid_o);

  // R8
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  // R9
  unavail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !vec_en_i) |=> (unavail_o && !out_valid_o &&
                                   $stable(result_o) && $stable(lane_sat_o)));

  // R6
  lane_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (|lane_sat_o)) |-> sat_sticky_o);

  // R9
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && unavail_o));

endmodule

// File: tb/psum_sat_unit_tb.sv
`timescale 1ns/1ps
module psum_sat_unit_tb_top;

  logic         clk;
  logic         rst_n;
  logic         in_valid, vec_en, sat_clr;
  logic [127:0] opa, opb;
  logic         out_valid, sticky, unavail;
  logic [127:0] result;
  logic [1:0]   lane_sat;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  psum_sat_unit dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .in_valid_i   (in_valid),
    .vec_en_i     (vec_en),
    .sat_clr_i    (sat_clr),
    .opa_i        (opa),
    .opb_i        (opb),
    .out_valid_o  (out_valid),
    .result_o     (result),
    .lane_sat_o   (lane_sat),
    .sat_sticky_o (sticky),
    .unavail_o    (unavail)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam int NV = 6;
  localparam logic [127:0] TA [NV] = '{
    {32'h00000001, 32'h00000002, 32'h00000003, 32'h00000004},
    {32'hFFFFFFFF, 32'hFFFFFFFE, 32'h7FFFFFFF, 32'h00000001},
    {32'h7FFFFFFF, 32'h7FFFFFFF, 32'h00000005, 32'h00000006},
    {32'h80000000, 32'h00000001, 32'h80000000, 32'h80000000},
    {32'h40000000, 32'h40000000, 32'hC0000000, 32'hC0000000},
    {32'h7FFFFFFE, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF}
  };
  localparam logic [127:0] TB [NV] = '{
    {32'hDEADBEEF, 32'h00000010, 32'h12345678, 32'h00000020},
    {32'hAAAAAAAA, 32'hFFFFFFFD, 32'h55555555, 32'hFFFFFFFF},
    {32'h00000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000007},
    {32'h11111111, 32'hFFFFFFFF, 32'h22222222, 32'h80000000},
    {32'h00000000, 32'h00000001, 32'h00000000, 32'hFFFFFFFF},
    {32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF}
  };
  localparam logic [63:0] TR [NV] = '{
    {32'h00000013, 32'h00000027},
    {32'hFFFFFFFA, 32'h7FFFFFFF},
    {32'h7FFFFFFF, 32'h00000012},
    {32'h80000000, 32'h80000000},
    {32'h7FFFFFFF, 32'h80000000},
    {32'h7FFFFFFF, 32'hFFFFFFFD}
  };
  localparam logic [1:0] TS [NV] = '{2'b00, 2'b00, 2'b01, 2'b10, 2'b11, 2'b00};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request at a negedge, sample at the following negedge.
  task automatic issue(input logic [127:0] a, input logic [127:0] b,
                       input logic en, input logic clr);
    @(negedge clk);
    opa = a; opb = b; in_valid = 1'b1; vec_en = en; sat_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
  endtask

  task automatic clear_only();
    @(negedge clk);
    sat_clr = 1'b1;
    @(negedge clk);
    sat_clr = 1'b0;
  endtask

  localparam logic [127:0] NOSAT_A = {32'h0, 32'h1, 32'h0, 32'h1};
  localparam logic [127:0] SAT_A   = {32'h7FFFFFFF, 32'h7FFFFFFF, 32'h0, 32'h0};
  localparam logic [127:0] ZERO    = '0;

  initial begin
    logic [127:0] held;
    in_valid = 0; vec_en = 1; sat_clr = 0; opa = '0; opb = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", {127'd0, out_valid}, '0);
    chk("R10 result", result, '0);
    chk("R10 lane_sat", {126'd0, lane_sat}, '0);
    chk("R10 sticky", {127'd0, sticky}, '0);
    chk("R10 unavail", {127'd0, unavail}, '0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(TA[i], TB[i], 1'b1, 1'b0);
      chk("R8 out_valid", {127'd0, out_valid}, 128'd1);
      chk("R1 R4 word1", {96'd0, result[95:64]}, {96'd0, TR[i][63:32]});
      chk("R2 R4 word3", {96'd0, result[31:0]}, {96'd0, TR[i][31:0]});
      chk("R3 even words", {64'd0, result[127:96], result[63:32]}, '0);
      chk("R5 lane_sat", {126'd0, lane_sat}, {126'd0, TS[i]});
    end
    // R8 idle cycle drops valid
    @(negedge clk);
    chk("R8 idle", {127'd0, out_valid}, '0);

    // R7 clear, R6 set and hold
    clear_only();
    chk("R7 clear", {127'd0, sticky}, '0);
    issue(NOSAT_A, ZERO, 1'b1, 1'b0);
    chk("R6 no set", {127'd0, sticky}, '0);
    issue(SAT_A, ZERO, 1'b1, 1'b0);
    chk("R6 set", {127'd0, sticky}, 128'd1);
    issue(NOSAT_A, ZERO, 1'b1, 1'b0);
    chk("R6 hold", {127'd0, sticky}, 128'd1);
    chk("R5 flags cleared", {126'd0, lane_sat}, '0);
    issue(SAT_A, ZERO, 1'b1, 1'b1);
    chk("R7 set wins", {127'd0, sticky}, 128'd1);
    issue(NOSAT_A, ZERO, 1'b1, 1'b1);
    chk("R7 clear with op", {127'd0, sticky}, '0);

    // R9 disabled facility
    held = result;
    issue(SAT_A, ZERO, 1'b0, 1'b0);
    chk("R9 unavail", {127'd0, unavail}, 128'd1);
    chk("R9 no valid", {127'd0, out_valid}, '0);
    chk("R9 result held", result, held);
    chk("R9 lane_sat held", {126'd0, lane_sat}, '0);
    chk("R9 sticky held", {127'd0, sticky}, '0);
    @(negedge clk);
    chk("R9 unavail pulse", {127'd0, unavail}, '0);

    // R10 reset mid-run
    issue(SAT_A, ZERO, 1'b1, 1'b0);
    rst_n = 0;
    #1;
    chk("R10 async result", result, '0);
    chk("R10 async sticky", {127'd0, sticky}, '0);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule